// File: doc/BRIEF.md
# Encoded Ratio Clock Divider

This block divides a fast input clock by an integer ratio picked from a 4-bit code, and drives a group of output clocks that share that ratio. The low two code bits pick an odd or small base ratio from one of two tables, chosen by a table-select input. The high two code bits scale the base by a power of two. The result covers every ratio from /2 to /72 that those tables can form. Every output keeps an exact 50 % duty cycle. For odd ratios this is done by stretching the high phase on a falling input-clock edge.

The ratio, a group-wide phase inversion and one run bit per output can all change at run time. The block samples each of these only at the end of a period of the divided waveform, which is the moment the non-inverted waveform falls. Changing them therefore never shortens a high pulse. An active-low power-down input is sampled on the input clock. Once it has been seen low on two consecutive rising edges, every output is held low from the next period end. The outputs restart at a period end after the input returns high.

Top module: `clkdiv_group`

## Requirements
- R1: With table_sel = 0, ratio_code[1:0] = 00, 01, 10, 11 gives base ratios 2, 3, 5, 7.
- R2: With table_sel = 1, ratio_code[1:0] = 00, 01, 10, 11 gives base ratios 4, 3, 5, 9.
- R3: ratio_code[3:2] = 00, 01, 10, 11 multiplies the base by 1, 2, 4, 8. The output period is ratio input cycles, from /2 up to /72.
- R4: Each output is high for exactly ratio/2 input cycles. For odd ratios the extra half cycle comes from a falling input-clock edge.
- R5: When invert = 1, each running output is the complement of the divided waveform. For odd ratios, a non-inverted output rises on a falling input-clock edge and an inverted output rises on a rising input-clock edge.
- R6: out_en[i] = 0 holds clk_out[i] low. The other outputs are not affected.
- R7: Changes of ratio, table, inversion and enable take effect only at a period end, where the non-inverted waveform falls. No high pulse is ever shorter than half the smaller of the old and new ratios. An output that is re-enabled begins with a complete high pulse.
- R8: pd_n seen low on two consecutive rising clock edges holds all outputs low from the next period end for as long as it stays low. A pd_n low for a single clock edge has no effect.
- R9: After pd_n returns high, the outputs resume at a period end with full-width pulses of the current ratio.
- R10: While rst_n is low all outputs are low. After rst_n rises, the divider starts at /2. With code 0 applied, the first rising edge of clk_out appears on the third rising clock edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_code | input | 4 | [1:0] base select, [3:2] power-of-two multiplier |
| table_sel | input | 1 | 0 selects table {2,3,5,7}, 1 selects table {4,3,5,9} |
| invert | input | 1 | Group-wide phase inversion |
| out_en | input | NUM_OUT | Per-output run bit, 1 = running |
| pd_n | input | 1 | Active-low power-down request |
| clk_out | output | NUM_OUT | Divided output clocks |

## Verification
The bench targets pulse integrity at the moments where gating decisions are made:
- It drops an enable mid-pulse, switches from /8 to /2 during a high phase, and enters power-down while the outputs toggle. A design that applied these immediately would show high pulses shorter than the expected width, and a width monitor on the output catches them.
- For odd ratios it checks the clock level at each output rising edge. A divider that used whole-cycle high phases would lose the 50 % duty and put its rising edges on the wrong clock polarity.
- A one-cycle power-down glitch must not stop the outputs. A filter that reacted to a single sample would freeze them.
- Table and multiplier decode are checked by measured period and high time at /3, /7, /9 and /72. These expose swapped table entries or a wrong shift.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
   localparam int CODE_W = 4;
   localparam int SMALLEST_TOP_RATIO = 72;

   // base ratio from table select and low code field
   function automatic logic [3:0] base_of(input logic tab, input logic [1:0] sel);
      logic [3:0] b;
      case ({tab, sel})
         3'b000:  b = 4'd2;
         3'b001:  b = 4'd3;
         3'b010:  b = 4'd5;
         3'b011:  b = 4'd7;
         3'b100:  b = 4'd4;
         3'b101:  b = 4'd3;
         3'b110:  b = 4'd5;
         default: b = 4'd9;
      endcase
      return b;
   endfunction
endpackage

// File: rtl/cdv_ratio_decode.sv
`timescale 1ns/1ps
module cdv_ratio_decode
   import clkdiv_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic [CODE_W-1:0] code,
   input  logic              tab,
   output logic [CNT_W-1:0]  ratio,
   output logic [CNT_W-1:0]  high_len
);
   logic [3:0] base;

   always_comb begin
      base     = base_of(tab, code[1:0]);
      ratio    = CNT_W'(base) << code[3:2];
      high_len = (ratio + CNT_W'(1)) >> 1;
   end
endmodule

// File: rtl/cdv_phase_core.sv
`timescale 1ns/1ps
module cdv_phase_core #(
   parameter int CNT_W          = 7,
   parameter bit HALF_CYCLE_ODD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] ratio_in,
   input  logic [CNT_W-1:0] high_in,
   output logic             wrap,
   output logic             div_out
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] ratio_q;
   logic [CNT_W-1:0] high_q;
   logic             a_hi;

   assign wrap = (cnt_q == ratio_q - CNT_W'(1));
   assign a_hi = (cnt_q >= (ratio_q - high_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         ratio_q <= CNT_W'(2);
         high_q  <= CNT_W'(1);
      end else if (wrap) begin
         cnt_q   <= '0;
         ratio_q <= ratio_in;
         high_q  <= high_in;
      end else begin
         cnt_q   <= cnt_q + CNT_W'(1);
      end
   end

   generate
      if (HALF_CYCLE_ODD) begin : g_half
         logic b_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) b_q <= 1'b0;
            else        b_q <= a_hi;
         end
         assign div_out = ratio_q[0] ? (a_hi & b_q) : a_hi;
      end else begin : g_whole
         assign div_out = a_hi;
      end
   endgenerate

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < ratio_q);
   // R7
   ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_q != $past(ratio_q)) |-> $past(wrap));
   // R7
   fall_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(a_hi) |-> $past(wrap));
endmodule

// File: rtl/cdv_pd_filter.sv
`timescale 1ns/1ps
module cdv_pd_filter #(
   parameter int PD_SAMPLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_n,
   output logic pd_req
);
   logic [PD_SAMPLES-1:0] seen_low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_low_q <= '0;
      else        seen_low_q <= {seen_low_q[PD_SAMPLES-2:0], ~pd_n};
   end

   assign pd_req = &seen_low_q;

   // R8
   pd_recent_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pd_req |-> !$past(pd_n));
endmodule

// File: rtl/cdv_out_gate.sv
`timescale 1ns/1ps
module cdv_out_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap,
   input  logic div_in,
   input  logic invert,
   input  logic enable,
   input  logic pd_req,
   output logic clk_out
);
   logic run_q;
   logic inv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         inv_q <= 1'b0;
      end else if (wrap) begin
         run_q <= enable & ~pd_req;
         inv_q <= invert;
      end
   end

   assign clk_out = run_q & (div_in ^ inv_q);

   // R7
   run_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q != $past(run_q)) |-> $past(wrap));
   // R8
   pd_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && pd_req) |=> !run_q);
   // R6
   disabled_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !enable) |=> !clk_out);
endmodule

// File: rtl/clkdiv_group.sv
`timescale 1ns/1ps
module clkdiv_group
   import clkdiv_pkg::*;
#(
   parameter int NUM_OUT        = 4,
   parameter int MAX_RATIO      = 72,
   parameter int PD_SAMPLES     = 2,
   parameter bit HALF_CYCLE_ODD = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CODE_W-1:0]  ratio_code,
   input  logic               table_sel,
   input  logic               invert,
   input  logic [NUM_OUT-1:0] out_en,
   input  logic               pd_n,
   output logic [NUM_OUT-1:0] clk_out
);
   localparam int CNT_W = $clog2(MAX_RATIO + 1);

   generate
      if (MAX_RATIO < SMALLEST_TOP_RATIO) begin : g_bad_ratio
         $error("MAX_RATIO must cover the largest encodable ratio");
      end
      if (NUM_OUT < 1) begin : g_bad_outs
         $error("NUM_OUT must be at least one");
      end
      if (PD_SAMPLES < 2) begin : g_bad_pd
         $error("PD_SAMPLES must be at least two");
      end
   endgenerate

   logic [CNT_W-1:0] ratio_w;
   logic [CNT_W-1:0] high_w;
   logic             wrap_w;
   logic             div_w;
   logic             pd_req_w;

   cdv_ratio_decode #(.CNT_W(CNT_W)) u_dec (
      .code     (ratio_code),
      .tab      (table_sel),
      .ratio    (ratio_w),
      .high_len (high_w)
   );

   cdv_phase_core #(.CNT_W(CNT_W), .HALF_CYCLE_ODD(HALF_CYCLE_ODD)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .ratio_in (ratio_w),
      .high_in  (high_w),
      .wrap     (wrap_w),
      .div_out  (div_w)
   );

   cdv_pd_filter #(.PD_SAMPLES(PD_SAMPLES)) u_pd (
      .clk    (clk),
      .rst_n  (rst_n),
      .pd_n   (pd_n),
      .pd_req (pd_req_w)
   );

   generate
      for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
         cdv_out_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .wrap    (wrap_w),
            .div_in  (div_w),
            .invert  (invert),
            .enable  (out_en[i]),
            .pd_req  (pd_req_w),
            .clk_out (clk_out[i])
         );
      end
   endgenerate

   // R10
   reset_low_chk: assert property (@(posedge clk) !rst_n |-> (clk_out == '0));
endmodule

// File: tb/tb_clkdiv_group.sv
`timescale 1ns/1ps
module tb_clkdiv_group;
   localparam int NOUT = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [3:0]      ratio_code = 4'd0;
   logic            table_sel = 1'b0;
   logic            invert = 1'b0;
   logic [NOUT-1:0] out_en = '1;
   logic            pd_n = 1'b1;
   logic [NOUT-1:0] clk_out;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int min_hi = 0;
   int rises [NOUT];
   realtime last_rise = 0;

   clkdiv_group #(.NUM_OUT(NOUT)) dut (
      .clk(clk), .rst_n(rst_n), .ratio_code(ratio_code), .table_sel(table_sel),
      .invert(invert), .out_en(out_en), .pd_n(pd_n), .clk_out(clk_out)
   );

   always #10 clk = ~clk;

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog all requirements: cycles=%0d expected below 150000", cyc);
         summary();
         $finish;
      end
   end

   for (genvar g = 0; g < NOUT; g++) begin : g_cnt
      initial rises[g] = 0;
      always @(posedge clk_out[g]) rises[g]++;
   end

   // runt monitor on output 0 (R7)
   always @(posedge clk_out[0]) last_rise = $realtime;
   always @(negedge clk_out[0]) begin
      if (min_hi > 0) begin
         checks++;
         if (($realtime - last_rise) < min_hi) begin
            fails++;
            $display("FAIL R7 short pulse: actual=%0d expected>=%0d",
                     int'($realtime - last_rise), min_hi);
         end
      end
   end

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic measure(output int per, output int hi);
      realtime t0, t1, t2;
      @(posedge clk_out[0]); t0 = $realtime;
      @(negedge clk_out[0]); t1 = $realtime;
      @(posedge clk_out[0]); t2 = $realtime;
      per = int'(t2 - t0);
      hi  = int'(t1 - t0);
   endtask

   task automatic set_ratio(input logic tab, input logic [3:0] code);
      @(negedge clk);
      table_sel  = tab;
      ratio_code = code;
      cycles(200);
   endtask

   task automatic expect_ratio(input string req, input int n);
      int per, hi;
      measure(per, hi);
      check_eq(req, "period ns", per, 20 * n);
      check_eq("R4", "high ns", hi, 10 * n);
   endtask

   task automatic t_reset();
      realtime tr;
      cycles(5);
      check_eq("R10", "outputs in reset", int'(clk_out), 0);
      tr = $realtime;
      rst_n = 1'b1;
      @(posedge clk_out[0]);
      check_eq("R10", "first rise delay ns", int'($realtime - tr), 50);
   endtask

   task automatic t_table_a();
      set_ratio(1'b0, 4'b0000); expect_ratio("R1", 2);
      set_ratio(1'b0, 4'b0001); expect_ratio("R1", 3);
      set_ratio(1'b0, 4'b0010); expect_ratio("R1", 5);
      set_ratio(1'b0, 4'b0011); expect_ratio("R1", 7);
   endtask

   task automatic t_table_b();
      set_ratio(1'b1, 4'b0000); expect_ratio("R2", 4);
      set_ratio(1'b1, 4'b0001); expect_ratio("R2", 3);
      set_ratio(1'b1, 4'b0011); expect_ratio("R2", 9);
   endtask

   task automatic t_mult();
      set_ratio(1'b0, 4'b0101); expect_ratio("R3", 6);
      set_ratio(1'b0, 4'b1000); expect_ratio("R3", 8);
      set_ratio(1'b1, 4'b1111); expect_ratio("R3", 72);
   endtask

   task automatic t_invert();
      int per, hi;
      set_ratio(1'b0, 4'b0001);
      @(posedge clk_out[0]); #1;
      check_eq("R5", "clk level at rise, normal", int'(clk), 0);
      @(negedge clk); invert = 1'b1;
      cycles(20);
      @(posedge clk_out[0]); #1;
      check_eq("R5", "clk level at rise, inverted", int'(clk), 1);
      measure(per, hi);
      check_eq("R5", "inverted period ns", per, 60);
      check_eq("R5", "inverted high ns", hi, 30);
      @(negedge clk); invert = 1'b0;
      cycles(20);
   endtask

   task automatic t_enable();
      int r0, r1, per, hi;
      realtime t0;
      set_ratio(1'b0, 4'b1000);
      min_hi = 80;
      @(negedge clk); out_en[1] = 1'b0;
      cycles(40);
      r0 = rises[0]; r1 = rises[1];
      cycles(100);
      check_eq("R6", "disabled output rises", rises[1] - r1, 0);
      check_eq("R6", "other output keeps running", int'(rises[0] - r0 > 0), 1);
      @(posedge clk_out[0]); t0 = $realtime;
      cycles(1); out_en[0] = 1'b0;
      @(negedge clk_out[0]);
      check_eq("R7", "last pulse before disable ns", int'($realtime - t0), 80);
      cycles(40);
      check_eq("R6", "disabled output level", int'(clk_out[0]), 0);
      cycles(3); out_en[0] = 1'b1;
      @(posedge clk_out[0]); t0 = $realtime;
      @(negedge clk_out[0]);
      check_eq("R7", "first pulse after enable ns", int'($realtime - t0), 80);
      @(negedge clk); out_en = '1;
      cycles(40);
   endtask

   task automatic t_ratio_change();
      realtime t0;
      min_hi = 20;
      @(posedge clk_out[0]); t0 = $realtime;
      cycles(2); ratio_code = 4'b0000; table_sel = 1'b0;
      @(negedge clk_out[0]);
      check_eq("R7", "pulse spanning ratio change ns", int'($realtime - t0), 80);
      cycles(10);
      expect_ratio("R7", 2);
   endtask

   task automatic t_pd();
      int r0, sum0, sum1, per, hi;
      r0 = rises[0];
      @(negedge clk); pd_n = 1'b0;
      @(negedge clk); pd_n = 1'b1;
      cycles(20);
      check_eq("R8", "single-sample pd ignored", int'(rises[0] - r0 >= 8), 1);
      @(negedge clk); pd_n = 1'b0;
      cycles(12);
      sum0 = rises[0] + rises[1] + rises[2] + rises[3];
      cycles(100);
      sum1 = rises[0] + rises[1] + rises[2] + rises[3];
      check_eq("R8", "rises during power-down", sum1 - sum0, 0);
      check_eq("R8", "outputs during power-down", int'(clk_out), 0);
      @(negedge clk); pd_n = 1'b1;
      cycles(10);
      measure(per, hi);
      check_eq("R9", "period after resume ns", per, 40);
      check_eq("R9", "high after resume ns", hi, 20);
      check_eq("R9", "all outputs resumed", int'(rises[3] > 0), 1);
      min_hi = 0;
   endtask

   initial begin
      t_reset();
      t_table_a();
      t_table_b();
      t_mult();
      t_invert();
      t_enable();
      t_ratio_change();
      t_pd();
      summary();
      $finish;
   end
endmodule